// File: doc/BRIEF.md
# Dual-Channel Parallel Converter Write Sequencer

This block sits between on-chip logic and the digital pins of a two-channel, 8-bit, parallel-load voltage converter. The converter has one shared data bus, a single channel-select bit, an active-low load strobe and an active-high power-down line. Requests arrive on a valid/ready handshake. Each request is either a code write to one channel or a power command. The sequencer turns each request into a pin sequence that meets the part's nanosecond limits, and it never lets the bus or the select bit move while a strobe is open.

Every limit is written in nanoseconds and turned into whole clock cycles at elaboration, rounding up, from the clock frequency parameter. After a code write the block waits for the analog output to settle before it raises a one-cycle done pulse. Power-down and wake-up each have their own wait. A write issued while the part is powered down still loads the latch. Its done is deferred and comes from the wake-up that follows. Two shadow registers hold the last code loaded into each channel. They start at zero, which is the state the converter itself takes at power-up.

Top module: `dac_wr_seq`

## Requirements
- R1: Out of reset the strobe is high, the power-down line is low, ready is high, done is low and both shadow codes are 0x00.
- R2: Select value 0 addresses channel A and value 1 addresses channel B. A write changes only the shadow code of the selected channel.
- R3: The select bit and data bus are set up at least ceil(5 ns) cycles before the strobe falls. They stay unchanged from that point through the first cycle after the strobe rises.
- R4: The strobe is low for max(ceil(20 ns), ceil(25 ns) − ceil(5 ns)) cycles, so the data setup before the rising edge is at least ceil(25 ns) cycles.
- R5: For a write while powered up, done is a single-cycle pulse. It comes 1 + ceil(6 µs) cycles after the strobe rises, counting the hold cycle.
- R6: Ready is low from acceptance until the cycle that done is shown. A request held valid during that time is not taken and causes no strobe.
- R7: A power command with the sleep bit set drives the power-down line high in the cycle after acceptance. Done follows ceil(20 µs) cycles later.
- R8: A write accepted while powered down still strobes the latch and updates the shadow code, but it produces no done pulse.
- R9: A power command with the sleep bit clear drives the power-down line low in the cycle after acceptance. Done follows ceil(13 µs) cycles later.
- R10: Every wait equals ceil(t × CLK_FREQ_HZ / 1e9) clock cycles, with a minimum of one.
- R11: The ideal output level of each channel, shadow code × Vref / 256, follows the sequence of codes written to that channel, including 0x00 and 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_pwr | input | 1 | 1 = power command, 0 = code write |
| req_sleep | input | 1 | For power commands: 1 = power down, 0 = wake |
| req_chan | input | 1 | Target channel for writes (0 = A, 1 = B) |
| req_code | input | 8 | Code for writes |
| dac_addr | output | 1 | Converter channel-select pin |
| dac_data | output | 8 | Converter data bus |
| dac_wr_n | output | 1 | Converter load strobe, active low |
| dac_sdn | output | 1 | Converter power-down line, active high |
| done | output | 1 | One-cycle completion pulse |
| shadow_a | output | 8 | Last code loaded into channel A |
| shadow_b | output | 8 | Last code loaded into channel B |

## Verification
A fault in the phase counter or state register shows up first on the strobe. A pulse that is too short, or a setup count that is too short, can be seen within a few cycles of acceptance. A wrong settle, sleep or wake count shows up only when done arrives, thousands of cycles later, as a count off the expected value. A bad power-state flag shows up either as a done pulse after a write in shutdown, or as a missing one. A shadow register loaded from the wrong channel shows up on the shadow outputs in the cycle after the hold cycle.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ASU,
    ST_LOW,
    ST_HOLD,
    ST_SETTLE,
    ST_SLEEP,
    ST_WAKE
  } seq_state_e;

  // Nanoseconds to clock cycles, rounded up, never below one.
  function automatic int ns_to_cyc(longint ns, longint hz);
    longint c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  AST_TMR_STAYS_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && expired) |=> expired); // R10

endmodule

// File: rtl/dac_shadow_regs.sv
module dac_shadow_regs #(
  parameter int NCH = 2,
  parameter int DW  = 8,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap,
  input  logic [SW-1:0]           sel,
  input  logic [DW-1:0]           code,
  output logic [NCH-1:0][DW-1:0]  shadow
);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic en;
    assign en = cap && (int'(sel) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  shadow[g] <= '0;
      else if (en) shadow[g] <= code;
    end
  end

endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
  import dac_seq_pkg::*;
#(
  parameter longint CLK_FREQ_HZ   = 250_000_000,
  parameter int     DW            = 8,
  parameter int     T_ADDR_SU_NS  = 5,
  parameter int     T_DATA_SU_NS  = 25,
  parameter int     T_PULSE_NS    = 20,
  parameter int     T_SETTLE_NS   = 6_000,
  parameter int     T_WAKE_NS     = 13_000,
  parameter int     T_SLEEP_NS    = 20_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_pwr,
  input  logic          req_sleep,
  input  logic          req_chan,
  input  logic [DW-1:0] req_code,
  output logic          dac_addr,
  output logic [DW-1:0] dac_data,
  output logic          dac_wr_n,
  output logic          dac_sdn,
  output logic          done,
  output logic [DW-1:0] shadow_a,
  output logic [DW-1:0] shadow_b
);

  localparam int AS_CYC  = ns_to_cyc(longint'(T_ADDR_SU_NS), CLK_FREQ_HZ);
  localparam int DS_CYC  = ns_to_cyc(longint'(T_DATA_SU_NS), CLK_FREQ_HZ);
  localparam int PW_CYC  = ns_to_cyc(longint'(T_PULSE_NS),   CLK_FREQ_HZ);
  localparam int LOW_CYC = imax(PW_CYC, DS_CYC - AS_CYC);
  localparam int ST_CYC  = ns_to_cyc(longint'(T_SETTLE_NS),  CLK_FREQ_HZ);
  localparam int WK_CYC  = ns_to_cyc(longint'(T_WAKE_NS),    CLK_FREQ_HZ);
  localparam int SL_CYC  = ns_to_cyc(longint'(T_SLEEP_NS),   CLK_FREQ_HZ);
  localparam int MAX_CYC = imax(imax(imax(AS_CYC, LOW_CYC), imax(ST_CYC, WK_CYC)), SL_CYC);
  localparam int CW      = $clog2(MAX_CYC + 1);

  seq_state_e    state_q, state_d;
  logic          sdn_q, sdn_d;
  logic          done_q, done_d;
  logic          addr_q;
  logic [DW-1:0] data_q;
  logic          take, cap;
  logic          tmr_load, tmr_exp;
  logic [CW-1:0] tmr_val;
  logic [1:0][DW-1:0] shadow;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    sdn_d    = sdn_q;
    done_d   = 1'b0;
    take     = 1'b0;
    cap      = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          tmr_load = 1'b1;
          if (req_pwr) begin
            sdn_d   = req_sleep;
            state_d = req_sleep ? ST_SLEEP : ST_WAKE;
            tmr_val = req_sleep ? CW'(SL_CYC - 1) : CW'(WK_CYC - 1);
          end else begin
            take    = 1'b1;
            state_d = ST_ASU;
            tmr_val = CW'(AS_CYC - 1);
          end
        end
      end
      ST_ASU: begin
        if (tmr_exp) begin
          state_d  = ST_LOW;
          tmr_load = 1'b1;
          tmr_val  = CW'(LOW_CYC - 1);
        end
      end
      ST_LOW: begin
        if (tmr_exp) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        cap = 1'b1;
        if (sdn_q) begin
          state_d = ST_IDLE;
        end else begin
          state_d  = ST_SETTLE;
          tmr_load = 1'b1;
          tmr_val  = CW'(ST_CYC - 1);
        end
      end
      ST_SETTLE, ST_SLEEP, ST_WAKE: begin
        if (tmr_exp) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sdn_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sdn_q   <= sdn_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= 1'b0;
      data_q <= '0;
    end else if (take) begin
      addr_q <= req_chan;
      data_q <= req_code;
    end
  end

  dac_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  dac_shadow_regs #(.NCH(2), .DW(DW)) u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap    (cap),
    .sel    (addr_q),
    .code   (data_q),
    .shadow (shadow)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign dac_addr  = addr_q;
  assign dac_data  = data_q;
  assign dac_wr_n  = (state_q != ST_LOW);
  assign dac_sdn   = sdn_q;
  assign done      = done_q;
  assign shadow_a  = shadow[0];
  assign shadow_b  = shadow[1];

  AST_BUS_STABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_n |-> ($stable(dac_addr) && $stable(dac_data))); // R3
  AST_BUS_HOLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_wr_n) |-> ($stable(dac_addr) && $stable(dac_data))); // R3
  AST_NOT_READY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_n |-> !req_ready); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_SHADOW_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow != $past(shadow)) |-> ($past(dac_wr_n, 2) == 1'b0)); // R2

endmodule

// File: tb/dac_wr_seq_bench.sv
`timescale 1ns/1ps
module dac_wr_seq_bench;

  localparam longint FHZ = 250_000_000;

  function automatic int cyc(longint ns);
    longint c;
    c = (ns * FHZ + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  localparam int E_AS  = cyc(5);
  localparam int E_DS  = cyc(25);
  localparam int E_PW  = cyc(20);
  localparam int E_ST  = cyc(6000);
  localparam int E_WK  = cyc(13000);
  localparam int E_SL  = cyc(20000);
  localparam int VREF_MV = 3300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_pwr = 1'b0, req_sleep = 1'b0, req_chan = 1'b0;
  logic [7:0] req_code = 8'h00;
  logic       req_ready, dac_addr, dac_wr_n, dac_sdn, done;
  logic [7:0] dac_data, shadow_a, shadow_b;

  int checks = 0;
  int fails  = 0;
  int wd     = 0;
  logic [7:0] exp_a = 8'h00, exp_b = 8'h00;

  always #2 clk = ~clk;

  dac_wr_seq u_dac_wr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pwr(req_pwr), .req_sleep(req_sleep), .req_chan(req_chan), .req_code(req_code),
    .dac_addr(dac_addr), .dac_data(dac_data), .dac_wr_n(dac_wr_n), .dac_sdn(dac_sdn),
    .done(done), .shadow_a(shadow_a), .shadow_b(shadow_b)
  );

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      chk(1'b0, "WD", "watchdog expired", wd, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Waits for ready, presents one request for the accepting edge.
  task automatic accept(bit pwr, bit slp, bit ch, logic [7:0] code);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_pwr = pwr; req_sleep = slp; req_chan = ch; req_code = code;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_levels(string tag);
    int mva, mvb;
    mva = int'(shadow_a) * VREF_MV / 256;
    mvb = int'(shadow_b) * VREF_MV / 256;
    chk(shadow_a == exp_a, tag, "shadow A code", shadow_a, exp_a);
    chk(shadow_b == exp_b, tag, "shadow B code", shadow_b, exp_b);
    chk(mva == int'(exp_a) * VREF_MV / 256, "R11", "channel A level mV", mva, int'(exp_a) * VREF_MV / 256);
    chk(mvb == int'(exp_b) * VREF_MV / 256, "R11", "channel B level mV", mvb, int'(exp_b) * VREF_MV / 256);
  endtask

  // Called at the negedge of the first cycle after acceptance.
  task automatic observe_write(bit ch, logic [7:0] code, bit asleep);
    int su = 0, lo = 0, n = 0;
    bit stable = 1'b1, busy = 1'b1, extra = 1'b0, early = 1'b0;
    chk(dac_addr == ch, "R2", "select bit", dac_addr, ch);
    chk(dac_data == code, "R3", "data bus", dac_data, code);
    while (dac_wr_n && su < 100) begin
      su++;
      if (dac_addr != ch || dac_data != code) stable = 1'b0;
      @(negedge clk);
    end
    while (!dac_wr_n && lo < 100) begin
      lo++;
      if (dac_addr != ch || dac_data != code) stable = 1'b0;
      if (req_ready) busy = 1'b0;
      @(negedge clk);
    end
    if (dac_addr != ch || dac_data != code) stable = 1'b0;
    chk(su >= E_AS, "R3", "address setup cycles", su, E_AS);
    chk(stable, "R3", "bus stable through hold", stable, 1);
    chk(lo == (E_PW > E_DS - E_AS ? E_PW : E_DS - E_AS), "R4", "strobe low cycles", lo,
        (E_PW > E_DS - E_AS ? E_PW : E_DS - E_AS));
    chk(su + lo >= E_DS, "R4", "data setup before rise", su + lo, E_DS);
    if (ch) exp_b = code; else exp_a = code;
    if (!asleep) begin
      while (!done && n < 20000) begin
        n++;
        if (req_ready) busy = 1'b0;
        if (!dac_wr_n) extra = 1'b1;
        @(negedge clk);
      end
      chk(n == E_ST + 1, "R5", "hold plus settle cycles to done", n, E_ST + 1);
      chk(busy, "R6", "ready low while busy", busy, 1);
      chk(!extra, "R6", "no strobe during settle", extra, 0);
      @(negedge clk);
      chk(!done, "R5", "done lasts one cycle", done, 0);
    end else begin
      for (int i = 0; i < E_ST + 100; i++) begin
        if (done) early = 1'b1;
        @(negedge clk);
      end
      chk(!early, "R8", "no done for write while powered down", early, 0);
      chk(req_ready, "R8", "ready after write in power-down", req_ready, 1);
    end
    check_levels("R2");
  endtask

  task automatic observe_power(bit slp);
    int n = 0;
    int expn;
    expn = slp ? E_SL : E_WK;
    chk(dac_sdn == slp, slp ? "R7" : "R9", "power-down line", dac_sdn, slp);
    while (!done && n < 20000) begin
      n++;
      @(negedge clk);
    end
    chk(n == expn, slp ? "R7" : "R9", "cycles to done", n, expn);
    chk(n == expn, "R10", "rounded-up wait length", n, expn);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(dac_wr_n == 1'b1, "R1", "strobe at reset", dac_wr_n, 1);
    chk(dac_sdn == 1'b0, "R1", "power-down at reset", dac_sdn, 0);
    chk(req_ready == 1'b1, "R1", "ready at reset", req_ready, 1);
    chk(done == 1'b0, "R1", "done at reset", done, 0);
    chk(shadow_a == 8'h00 && shadow_b == 8'h00, "R1", "shadows at reset", {shadow_a, shadow_b}, 0);
  endtask

  task automatic t_write(bit ch, logic [7:0] code);
    accept(1'b0, 1'b0, ch, code);
    observe_write(ch, code, 1'b0);
  endtask

  task automatic t_queued;
    logic [7:0] b_before;
    b_before = shadow_b;
    accept(1'b0, 1'b0, 1'b0, 8'h81);
    req_valid = 1'b1; req_pwr = 1'b0; req_chan = 1'b1; req_code = 8'h7F;
    observe_write(1'b0, 8'h81, 1'b0);
    chk(shadow_b == b_before, "R6", "held request not taken early", shadow_b, b_before);
    req_valid = 1'b0;
    observe_write(1'b1, 8'h7F, 1'b0);
  endtask

  task automatic t_sleep_write_wake;
    accept(1'b1, 1'b1, 1'b0, 8'h00);
    observe_power(1'b1);
    accept(1'b0, 1'b0, 1'b1, 8'h42);
    observe_write(1'b1, 8'h42, 1'b1);
    chk(dac_sdn == 1'b1, "R8", "still powered down", dac_sdn, 1);
    accept(1'b1, 1'b0, 1'b0, 8'h00);
    observe_power(1'b0);
    check_levels("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write(1'b0, 8'h3C);
    t_write(1'b1, 8'hF0);
    t_write(1'b0, 8'hFF);
    t_write(1'b0, 8'h00);
    t_queued();
    t_sleep_write_wake();
    t_write(1'b0, 8'hA5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule